// File: doc/BRIEF.md
# Bounded Descending Memory Stack Controller

This block manages a last-in first-out stack held in an external word-addressed synchronous memory. It keeps one top-of-stack pointer. The pointer moves toward lower addresses as words are added. It stays between a fixed empty boundary and a fixed full boundary. Stored words never move in memory. A push or a pop changes only the pointer and, for a push, the one word it writes.

A client raises a push request with a data word, or a pop request, while the unit is idle. The unit answers with a one-cycle done strobe and a one-bit status. A status of 0 means success. A status of 1 means the request would have overflowed or underflowed the stack and was refused. A refused request leaves both the pointer and the memory as they were. A pop delivers its word together with its done strobe. The current pointer is visible on an output so that a host can track the stack depth.

Top module: `lifo_mem_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the stack pointer equals the empty boundary 0x3000, done is 0 and the memory write enable is 0.
- R2: An accepted push with the pointer above 0x2000 lowers the pointer by one first. In the next cycle it drives write enable high with the address equal to the new pointer and the write data equal to the pushed word. In that same cycle done is 1 and status is 0.
- R3: An accepted pop with the pointer below 0x3000 presents the current pointer on the memory address in the next cycle. One cycle later done is 1, status is 0 and the popped word shows the memory read data. After that cycle the pointer is one higher.
- R4: A pop requested while the pointer equals 0x3000 gives done with status 1 in the cycle after acceptance. The pointer stays unchanged and no memory write occurs.
- R5: A push requested while the pointer equals 0x2000 gives done with status 1 in the cycle after acceptance. The pointer stays unchanged and no memory write occurs.
- R6: Words come back from pops in the reverse order of their pushes, including across a complete fill to the full boundary and a complete drain to empty.
- R7: Push or pop requests seen while an operation is in progress are ignored. They cause no write, no pointer change and no extra done strobe.
- R8: When push and pop are requested in the same idle cycle, the push is performed and the pop is dropped.
- R9: Done is high for exactly one cycle per accepted operation. Write enable is high only in a successful push's done cycle. The pointer never leaves the range 0x2000 to 0x3000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Request to add push_word; sampled only when idle |
| push_word | input | DATA_W | Word to store on a push |
| pop_req | input | 1 | Request to remove the top word; sampled only when idle |
| done | output | 1 | One-cycle completion strobe |
| fail | output | 1 | Status with done: 0 success, 1 overflow or underflow |
| pop_word | output | DATA_W | Popped word, valid while done is high after a successful pop |
| stack_ptr | output | ADDR_W | Current top-of-stack pointer |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the address |

## Verification
A pointer that is off by one appears on the write address in the done cycle of the very next push. It also appears as a wrong popped word two cycles after the next pop. A pointer that drifted past a boundary, or a boundary compare done after the pointer moved, shows up at the first refused operation. That operation then reports success, or it changes the pointer. A sequencer stuck in a busy state shows up as a missing or repeated done strobe within one or two cycles of the request.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RADDR,
        ST_RDATA,
        ST_REFUSE
    } lifo_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP
    } lifo_op_e;

endpackage

// File: rtl/lifo_arbiter.sv
module lifo_arbiter
    import lifo_pkg::*;
(
    input  logic     push_req,
    input  logic     pop_req,
    output lifo_op_e op
);
    // push wins over pop when both are raised together
    always_comb begin
        if (push_req)
            op = OP_PUSH;
        else if (pop_req)
            op = OP_POP;
        else
            op = OP_NONE;
    end
endmodule

// File: rtl/lifo_bounds.sv
module lifo_bounds #(
    parameter int unsigned           ADDR_W     = 16,
    parameter logic [ADDR_W-1:0]     EMPTY_ADDR = 'h3000,
    parameter logic [ADDR_W-1:0]     FULL_ADDR  = 'h2000
) (
    input  logic [ADDR_W-1:0] ptr,
    output logic              at_empty,
    output logic              at_full,
    output logic [ADDR_W-1:0] ptr_dec,
    output logic [ADDR_W-1:0] ptr_inc
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        at_empty = (ptr == EMPTY_ADDR);
        at_full  = (ptr == FULL_ADDR);
        ptr_dec  = ptr - ONE;
        ptr_inc  = ptr + ONE;
    end
endmodule

// File: rtl/lifo_seq.sv
module lifo_seq
    import lifo_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       DATA_W     = 16,
    parameter logic [ADDR_W-1:0] EMPTY_ADDR = 'h3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lifo_op_e          op,
    input  logic [DATA_W-1:0] push_word,
    input  logic              at_empty,
    input  logic              at_full,
    input  logic [ADDR_W-1:0] ptr_dec,
    input  logic [ADDR_W-1:0] ptr_inc,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              done,
    output logic              fail,
    output logic [DATA_W-1:0] pop_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we
);
    typedef struct packed {
        lifo_state_e       st;
        logic [ADDR_W-1:0] ptr;
        logic [DATA_W-1:0] wdata;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (op == OP_PUSH) begin
                    if (at_full) begin
                        nxt_d.st = ST_REFUSE;
                    end else begin
                        nxt_d.st    = ST_WRITE;
                        nxt_d.ptr   = ptr_dec;
                        nxt_d.wdata = push_word;
                    end
                end else if (op == OP_POP) begin
                    nxt_d.st = at_empty ? ST_REFUSE : ST_RADDR;
                end
            end
            ST_WRITE:  nxt_d.st = ST_IDLE;
            ST_RADDR:  nxt_d.st = ST_RDATA;
            ST_RDATA: begin
                nxt_d.st  = ST_IDLE;
                nxt_d.ptr = ptr_inc;
            end
            ST_REFUSE: nxt_d.st = ST_IDLE;
            default:   nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st    <= ST_IDLE;
            cur_q.ptr   <= EMPTY_ADDR;
            cur_q.wdata <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        ptr       = cur_q.ptr;
        mem_addr  = cur_q.ptr;
        mem_wdata = cur_q.wdata;
        mem_we    = (cur_q.st == ST_WRITE);
        done      = (cur_q.st == ST_WRITE) || (cur_q.st == ST_RDATA)
                 || (cur_q.st == ST_REFUSE);
        fail      = (cur_q.st == ST_REFUSE);
        pop_word  = (cur_q.st == ST_RDATA) ? mem_rdata : '0;
    end
endmodule

// File: rtl/lifo_mem_ctrl.sv
module lifo_mem_ctrl
    import lifo_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 16,
    parameter int unsigned       DATA_W     = 16,
    parameter logic [ADDR_W-1:0] EMPTY_ADDR = 'h3000,
    parameter logic [ADDR_W-1:0] FULL_ADDR  = 'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_word,
    input  logic              pop_req,
    output logic              done,
    output logic              fail,
    output logic [DATA_W-1:0] pop_word,
    output logic [ADDR_W-1:0] stack_ptr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);
    lifo_op_e          op;
    logic              at_empty, at_full;
    logic [ADDR_W-1:0] ptr_dec, ptr_inc;

    lifo_arbiter u_arb (
        .push_req (push_req),
        .pop_req  (pop_req),
        .op       (op)
    );

    lifo_bounds #(
        .ADDR_W     (ADDR_W),
        .EMPTY_ADDR (EMPTY_ADDR),
        .FULL_ADDR  (FULL_ADDR)
    ) u_bounds (
        .ptr      (stack_ptr),
        .at_empty (at_empty),
        .at_full  (at_full),
        .ptr_dec  (ptr_dec),
        .ptr_inc  (ptr_inc)
    );

    lifo_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .EMPTY_ADDR (EMPTY_ADDR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .push_word (push_word),
        .at_empty  (at_empty),
        .at_full   (at_full),
        .ptr_dec   (ptr_dec),
        .ptr_inc   (ptr_inc),
        .mem_rdata (mem_rdata),
        .ptr       (stack_ptr),
        .done      (done),
        .fail      (fail),
        .pop_word  (pop_word),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we)
    );
endmodule

// File: rtl/lifo_mem_ctrl_chk.sv
module lifo_mem_ctrl_chk #(
    parameter int unsigned       ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] EMPTY_ADDR = 'h3000,
    parameter logic [ADDR_W-1:0] FULL_ADDR  = 'h2000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              fail,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] stack_ptr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // R2
    push_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (done && !fail && mem_addr == stack_ptr
                    && stack_ptr == $past(stack_ptr) - ONE));

    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail && !mem_we) |=> (stack_ptr == $past(stack_ptr) + ONE));

    // R4
    refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && !mem_we && stack_ptr == $past(stack_ptr)));

    // R5
    refuse_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |=> $stable(stack_ptr));

    // R9
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_ptr >= FULL_ADDR && stack_ptr <= EMPTY_ADDR));
endmodule

bind lifo_mem_ctrl lifo_mem_ctrl_chk #(
    .ADDR_W     (ADDR_W),
    .EMPTY_ADDR (EMPTY_ADDR),
    .FULL_ADDR  (FULL_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .fail      (fail),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .stack_ptr (stack_ptr)
);

// File: tb/sim_lifo_mem_ctrl.sv
module sim_lifo_mem_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] EMPTY_A = 16'h3000;
    localparam logic [15:0] FULL_A  = 16'h2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0;
    logic        pop_req = 1'b0;
    logic [15:0] push_word = '0;
    logic        done, fail, mem_we;
    logic [15:0] pop_word, stack_ptr, mem_addr, mem_wdata, mem_rdata;

    logic [15:0] ram [0:4095];
    logic [15:0] model [0:4095];
    logic [15:0] exp_sp = EMPTY_A;
    int checks = 0;
    int failures = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lifo_mem_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_word(push_word),
        .pop_req(pop_req), .done(done), .fail(fail), .pop_word(pop_word),
        .stack_ptr(stack_ptr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
        mem_rdata <= ram[mem_addr[11:0]];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one operation with full expectation from the model
    task automatic op_check(input bit p, input bit q, input logic [15:0] w, input string req);
        int lat;
        logic f_seen, we_seen;
        logic [15:0] rd, wa, wd;
        bit do_push, exp_fail;
        int exp_lat;
        logic [15:0] exp_rd;
        do_push  = p;
        exp_fail = do_push ? (exp_sp == FULL_A) : (exp_sp == EMPTY_A);
        exp_lat  = (do_push || exp_fail) ? 1 : 2;
        exp_rd   = (!do_push && !exp_fail) ? model[exp_sp[11:0]] : 16'h0;
        @(negedge clk);
        push_req = p; pop_req = q; push_word = w;
        @(negedge clk);
        push_req = 0; pop_req = 0;
        lat = 1; we_seen = 0; wa = '0; wd = '0;
        while (!done && lat < 4) begin
            if (mem_we) we_seen = 1;
            @(negedge clk);
            lat++;
        end
        f_seen = fail; rd = pop_word;
        if (mem_we) begin we_seen = 1; wa = mem_addr; wd = mem_wdata; end
        chk({req, " latency"}, lat, exp_lat);
        chk({req, " status"}, {31'd0, f_seen}, {31'd0, exp_fail});
        if (do_push && !exp_fail) begin
            exp_sp = exp_sp - 16'd1;
            model[exp_sp[11:0]] = w;
            chk({req, " write"}, {15'd0, we_seen, wa}, {15'd0, 1'b1, exp_sp});
            chk({req, " wdata"}, {16'd0, wd}, {16'd0, w});
        end else begin
            chk({req, " no write"}, {31'd0, we_seen}, 32'd0);
            if (!exp_fail) begin
                chk({req, " data"}, {16'd0, rd}, {16'd0, exp_rd});
                exp_sp = exp_sp + 16'd1;
            end
        end
        @(negedge clk);
        chk({req, " ptr"}, {16'd0, stack_ptr}, {16'd0, exp_sp});
        chk({req, " single done"}, {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ptr in reset", {16'd0, stack_ptr}, {16'd0, EMPTY_A});
        chk("R1 done in reset", {31'd0, done}, 32'd0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 ptr after reset", {16'd0, stack_ptr}, {16'd0, EMPTY_A});
        chk("R1 we after reset", {31'd0, mem_we}, 32'd0);
    endtask

    task automatic t_pop_empty;
        op_check(0, 1, 16'h0, "R4 pop empty");
    endtask

    task automatic t_push_pop;
        op_check(1, 0, 16'h0012, "R2 push");
        op_check(1, 0, 16'h0031, "R2 push");
        op_check(1, 0, 16'h0005, "R2 push");
        op_check(1, 0, 16'h000c, "R2 push");
        op_check(0, 1, 16'h0, "R3 pop");
        op_check(0, 1, 16'h0, "R6 pop order");
        op_check(0, 1, 16'h0, "R6 pop order");
        op_check(0, 1, 16'h0, "R6 pop order");
    endtask

    task automatic t_priority;
        op_check(1, 1, 16'hA5A5, "R8 both push wins");
        op_check(0, 1, 16'h0, "R8 pop back");
    endtask

    task automatic t_busy;
        op_check(1, 0, 16'h1111, "R7 setup");
        @(negedge clk);
        pop_req = 1;
        @(negedge clk);
        pop_req = 0; push_req = 1; push_word = 16'hBEEF;
        chk("R7 no done in read", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk("R7 pop done", {31'd0, done}, 32'd1);
        chk("R7 pop data", {16'd0, pop_word}, 32'h1111);
        push_req = 0;
        exp_sp = exp_sp + 16'd1;
        @(negedge clk);
        chk("R7 no extra done", {31'd0, done}, 32'd0);
        chk("R7 no write", {31'd0, mem_we}, 32'd0);
        chk("R7 ptr", {16'd0, stack_ptr}, {16'd0, exp_sp});
        @(negedge clk);
        chk("R7 still idle", {30'd0, done, mem_we}, 32'd0);
    endtask

    task automatic t_fill_drain;
        for (int i = 0; i < 4096; i++)
            op_check(1, 0, 16'(i * 7 + 3), "R6 fill");
        chk("R5 at full", {16'd0, stack_ptr}, {16'd0, FULL_A});
        op_check(1, 0, 16'hDEAD, "R5 push full");
        for (int i = 0; i < 4096; i++)
            op_check(0, 1, 16'h0, "R6 drain");
        op_check(0, 1, 16'h0, "R4 pop after drain");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_pop_empty();
        t_push_pop();
        t_priority();
        t_busy();
        t_fill_drain();
        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule